// File: doc/BRIEF.md
# Single-Channel Patterned Byte Mover

This block is one channel of a direct memory access engine. It copies bytes between a wide memory bus (24-bit address, called side A here) and a narrow register bus (side B). Side B can reach a 256-entry window whose upper address byte is fixed at 0x21. Software programs a small byte-wide register file with a control byte, a B-side port, a 24-bit A address and a 16-bit byte count. It then pulses `go` with a cycle budget. The channel moves one byte every two cycles. Each byte takes one read cycle on the source bus and one write cycle on the destination bus. The transfer mode chooses which B register each byte lands on, and the channel reports the end of the transfer with a one-cycle `done` pulse.

A budget smaller than the full transfer makes the channel stop between bytes. It keeps its address, count and pattern position, stays busy, and continues on the next `go`. Only the low 16 bits of the A address step. The bank byte stays fixed.

The controller runs four states. S_IDLE is unarmed. S_READ is the source read cycle. S_WRITE is the destination write cycle. S_HOLD is armed but paused for lack of budget. The transitions are:
- IDLE→READ: `go` with a budget of at least 2.
- IDLE→HOLD: `go` with a budget of 0 or 1.
- HOLD→READ and HOLD→HOLD: on `go`, under the same budget rule.
- READ→WRITE: always.
- WRITE→IDLE: after the last byte, which also raises `done`.
- WRITE→READ: the remaining budget is at least 2.
- WRITE→HOLD: the remaining budget is below 2.

Top module: `dmac_channel`

## Requirements
- R1: After reset every register reads 0, `busy` and `done` are low and no bus strobe is active.
- R2: Register offsets on `reg_addr` are:
  - 0: control
  - 1: port
  - 2: A address bits 7:0
  - 3: A address bits 15:8
  - 4: A bank (bits 23:16)
  - 5: count bits 7:0
  - 6: count bits 15:8
  - 7: reads 0

  Every register reads back what was written, and `reg_rdata` is combinational.
- R3: Each byte is one cycle with a read strobe on the source bus, followed by one cycle with a write strobe on the destination bus. At most one strobe is high in any cycle. An n-byte transfer with enough budget spans 2n cycles from its first read to its last write.
- R4: Control bit 7 = 0 copies A→B (`a_rd` then `b_wr`). Bit 7 = 1 copies B→A (`b_rd` then `a_wr`). The written data equals the byte read in the previous cycle.
- R5: The B address is {0x21, port + offset}, where the 8-bit sum wraps.
- R6: Control bits 2:0 select the mode, and byte i takes offset pattern[i mod length]:
  - 000 → 0
  - 001 → 0,1
  - 010 → 0,0
  - 011 → 0,0,1,1
  - 100 → 0,1,2,3
- R7: Modes 101, 110 and 111 behave exactly as 001, 010 and 011.
- R8: Control bit 3 set keeps the A address fixed, and this takes priority over bit 4. Otherwise the A address steps by +1 after each byte when bit 4 = 0, and by −1 when bit 4 = 1.
- R9: A stepping wraps within the low 16 bits, and the bank never changes.
- R10: The count drops by one after each byte, and the transfer ends when it reaches 0. A count of 0 at start means 65536 bytes.
- R11: `done` is high for exactly one cycle, the cycle after the last write, and `busy` is low from then on.
- R12: Register writes while `busy` is high are ignored.
- R13: `go` loads `budget`. A byte starts only if at least 2 budget cycles remain, otherwise the channel pauses with `busy` high. A later `go` resumes it, with the address, count and offset pattern continuing where they stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| go | input | 1 | Start or resume pulse; loads budget |
| budget | input | 16 | Cycle budget for this run |
| busy | output | 1 | Channel armed (running or paused) |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | 24 | A bus address |
| a_rd | output | 1 | A bus read strobe |
| a_wr | output | 1 | A bus write strobe |
| a_wdata | output | 8 | A bus write data |
| a_rdata | input | 8 | A bus read data, valid in the read cycle |
| b_addr | output | 16 | B bus address |
| b_rd | output | 1 | B bus read strobe |
| b_wr | output | 1 | B bus write strobe |
| b_wdata | output | 8 | B bus write data |
| b_rdata | input | 8 | B bus read data, valid in the read cycle |

## Verification
The assertions assume three things about the inputs:
- Both read buses return data in the same cycle as the read strobe, with no wait states.
- `go` arrives only while the channel is idle or paused.
- Register writes during a transfer are meant to be dropped rather than merged.

The bench models both buses as combinational functions of the address. It drives `go` only when `busy` is low or the channel sits paused, and it deliberately writes registers in the middle of a transfer so that the lockout is exercised.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2,
        S_HOLD  = 2'd3
    } dmac_state_t;

    // control byte: bit7 direction, bits6:5 spare, bit4 step down, bit3 hold, bits2:0 mode
    typedef struct packed {
        logic       to_a;
        logic [1:0] spare;
        logic       step_dn;
        logic       hold_a;
        logic [2:0] mode;
    } dmac_ctrl_t;

    // per-byte offset added to the port for byte number idx (mod 4)
    function automatic logic [1:0] b_offset(input logic [2:0] mode, input logic [1:0] idx);
        logic [2:0] m;
        logic [1:0] off;
        m = (mode[2] && (mode[1:0] != 2'b00)) ? {1'b0, mode[1:0]} : mode;
        case (m)
            3'b001:  off = {1'b0, idx[0]};
            3'b011:  off = {1'b0, idx[1]};
            3'b100:  off = idx;
            default: off = 2'd0;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int PAGE_W = 16,
    parameter int BANK_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              lock,
    input  logic              step,
    output dmac_ctrl_t        ctrl_o,
    output logic [7:0]        port_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [7:0]        rdata_o
);

    dmac_ctrl_t        ctrl_q;
    logic [7:0]        port_q;
    logic [PAGE_W-1:0] page_q;
    logic [BANK_W-1:0] bank_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            port_q <= '0;
            page_q <= '0;
            bank_q <= '0;
            cnt_q  <= '0;
        end else if (we && !lock) begin
            unique case (addr)
                3'd0: ctrl_q       <= dmac_ctrl_t'(wdata);
                3'd1: port_q       <= wdata;
                3'd2: page_q[7:0]  <= wdata;
                3'd3: page_q[15:8] <= wdata;
                3'd4: bank_q       <= wdata;
                3'd5: cnt_q[7:0]   <= wdata;
                3'd6: cnt_q[15:8]  <= wdata;
                default: ;
            endcase
        end else if (step) begin
            if (!ctrl_q.hold_a)
                page_q <= ctrl_q.step_dn ? page_q - 1'b1 : page_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        unique case (addr)
            3'd0:    rdata_o = ctrl_q;
            3'd1:    rdata_o = port_q;
            3'd2:    rdata_o = page_q[7:0];
            3'd3:    rdata_o = page_q[15:8];
            3'd4:    rdata_o = bank_q;
            3'd5:    rdata_o = cnt_q[7:0];
            3'd6:    rdata_o = cnt_q[15:8];
            default: rdata_o = 8'h00;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign port_o = port_q;
    assign page_o = page_q;
    assign bank_o = bank_q;
    assign cnt_o  = cnt_q;

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt_q == $past(cnt_q) - 1'b1);
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> bank_q == $past(bank_q));
    p_fixed_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctrl_q.hold_a) |=> page_q == $past(page_q));
    p_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && we) |=> (ctrl_q == $past(ctrl_q) && port_q == $past(port_q)
                          && bank_q == $past(bank_q)));

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int BUD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [BUD_W-1:0] budget,
    input  logic             last,
    output dmac_state_t      state_o,
    output logic             step_o,
    output logic             done_o,
    output logic             busy_o,
    output logic             fresh_o
);

    localparam logic [BUD_W-1:0] CYC = BUD_W'(2);

    dmac_state_t      state, nxt;
    logic [BUD_W-1:0] bud;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            bud    <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (state == S_WRITE) && last;
            if ((state == S_IDLE || state == S_HOLD) && go)
                bud <= budget - CYC;
            else if (state == S_WRITE && nxt == S_READ)
                bud <= bud - CYC;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_HOLD: if (go) nxt = (budget >= CYC) ? S_READ : S_HOLD;
            S_READ:         nxt = S_WRITE;
            S_WRITE: begin
                if (last)            nxt = S_IDLE;
                else if (bud >= CYC) nxt = S_READ;
                else                 nxt = S_HOLD;
            end
            default:        nxt = S_IDLE;
        endcase
    end

    always_comb begin
        state_o = state;
        step_o  = (state == S_WRITE);
        busy_o  = (state != S_IDLE);
        fresh_o = (state == S_IDLE) && go;
        done_o  = done_q;
    end

    p_read_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_READ |=> state == S_WRITE);
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> state == S_IDLE);
    p_hold_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && go && budget < CYC) |=> state == S_HOLD);

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int         BUD_W  = 16,
    parameter logic [7:0] B_PAGE = 8'h21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             go,
    input  logic [BUD_W-1:0] budget,
    output logic             busy,
    output logic             done,
    output logic [23:0]      a_addr,
    output logic             a_rd,
    output logic             a_wr,
    output logic [7:0]       a_wdata,
    input  logic [7:0]       a_rdata,
    output logic [15:0]      b_addr,
    output logic             b_rd,
    output logic             b_wr,
    output logic [7:0]       b_wdata,
    input  logic [7:0]       b_rdata
);

    localparam int PAGE_W = 16;
    localparam int BANK_W = 8;
    localparam int CNT_W  = 16;

    dmac_ctrl_t        ctrl;
    logic [7:0]        port;
    logic [PAGE_W-1:0] page;
    logic [BANK_W-1:0] bank;
    logic [CNT_W-1:0]  cnt;
    dmac_state_t       state;
    logic              step, fresh;
    logic [1:0]        idx;
    logic [7:0]        hold_byte;

    dmac_regs #(.PAGE_W(PAGE_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .lock(busy), .step(step), .ctrl_o(ctrl), .port_o(port), .page_o(page),
        .bank_o(bank), .cnt_o(cnt), .rdata_o(reg_rdata)
    );

    dmac_seq #(.BUD_W(BUD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .budget(budget),
        .last(cnt == CNT_W'(1)), .state_o(state), .step_o(step),
        .done_o(done), .busy_o(busy), .fresh_o(fresh)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            hold_byte <= '0;
        end else begin
            if (fresh)     idx <= '0;
            else if (step) idx <= idx + 1'b1;
            if (state == S_READ)
                hold_byte <= ctrl.to_a ? b_rdata : a_rdata;
        end
    end

    always_comb begin
        a_addr  = {bank, page};
        b_addr  = {B_PAGE, port + {6'd0, b_offset(ctrl.mode, idx)}};
        a_rd    = (state == S_READ)  && !ctrl.to_a;
        b_rd    = (state == S_READ)  &&  ctrl.to_a;
        a_wr    = (state == S_WRITE) &&  ctrl.to_a;
        b_wr    = (state == S_WRITE) && !ctrl.to_a;
        a_wdata = hold_byte;
        b_wdata = hold_byte;
    end

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_rd, a_wr, b_rd, b_wr}));
    p_a_to_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |=> (b_wr && b_wdata == $past(a_rdata)));
    p_b_to_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd |=> (a_wr && a_wdata == $past(b_rdata)));

endmodule

// File: tb/test_dmac_channel.sv
module test_dmac_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        go = 1'b0;
    logic [15:0] budget = '0;
    logic        busy, done;
    logic [23:0] a_addr;
    logic        a_rd, a_wr, b_rd, b_wr;
    logic [7:0]  a_wdata, a_rdata, b_wdata, b_rdata;
    logic [15:0] b_addr;

    always #4 clk = ~clk;

    dmac_channel i_dmac_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .go(go), .budget(budget),
        .busy(busy), .done(done), .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .b_addr(b_addr), .b_rd(b_rd),
        .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    assign a_rdata = a_addr[7:0] ^ a_addr[15:8] ^ 8'h5A;
    assign b_rdata = b_addr[7:0] ^ 8'hC3;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  cnt;
        logic [15:0] offs;
        logic [15:0] endp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'd3, 16'h0000, 16'h1003},
        '{8'h01, 8'd4, 16'h4444, 16'h1004},
        '{8'h02, 8'd2, 16'h0000, 16'h1002},
        '{8'h03, 8'd8, 16'h5050, 16'h1008},
        '{8'h04, 8'd8, 16'hE4E4, 16'h1008},
        '{8'h05, 8'd4, 16'h4444, 16'h1004},
        '{8'h06, 8'd2, 16'h0000, 16'h1002},
        '{8'h07, 8'd8, 16'h5050, 16'h1008},
        '{8'h10, 8'd3, 16'h0000, 16'h0FFD},
        '{8'h08, 8'd3, 16'h0000, 16'h1000},
        '{8'h80, 8'd3, 16'h0000, 16'h1003},
        '{8'h84, 8'd4, 16'hE4E4, 16'h1004},
        '{8'h98, 8'd2, 16'h0000, 16'h1000},
        '{8'h91, 8'd4, 16'h4444, 16'h0FFC}
    };

    int n_tests = 0, n_fail = 0;
    int m_tests = 0, m_fail = 0;
    int cyc = 0;

    logic [7:0]  e_ctrl, e_port, e_bank;
    logic [15:0] e_page, e_offs;
    int          xfer_id = 0, seen_id = 0;
    bit          mon_on = 1'b0;
    int          bidx, nwr, dcnt, first_rd, last_wr, done_cyc;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mcheck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        m_tests++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s (bus): actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_a(input int i);
        logic [15:0] p;
        if (e_ctrl[3])      p = e_page;
        else if (e_ctrl[4]) p = e_page - 16'(i);
        else                p = e_page + 16'(i);
        return {e_bank, p};
    endfunction

    function automatic logic [15:0] exp_b(input int i);
        logic [1:0] off;
        off = e_offs[(i % 8) * 2 +: 2];
        return {8'h21, e_port + {6'd0, off}};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests + m_tests + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (xfer_id != seen_id) begin
            seen_id  = xfer_id;
            bidx     = 0; nwr = 0; dcnt = 0;
            first_rd = -1; last_wr = -1; done_cyc = -1;
        end
        if (mon_on && rst_n) begin
            mcheck($onehot0({a_rd, a_wr, b_rd, b_wr}), "R3", {a_rd, a_wr, b_rd, b_wr}, 0);
            if ((a_rd || b_rd) && first_rd < 0) first_rd = cyc;
            if (a_rd) mcheck(a_addr == exp_a(bidx), "R8", a_addr, exp_a(bidx));
            if (b_rd) mcheck(b_addr == exp_b(bidx), "R5", b_addr, exp_b(bidx));
            if (b_wr) begin
                mcheck(b_addr == exp_b(bidx), "R6", b_addr, exp_b(bidx));
                mcheck(b_wdata == (exp_a(bidx) & 24'hFF ^ (exp_a(bidx) >> 8) & 24'hFF ^ 8'h5A),
                       "R4", b_wdata, exp_a(bidx)[7:0] ^ exp_a(bidx)[15:8] ^ 8'h5A);
                nwr++; bidx++; last_wr = cyc;
            end
            if (a_wr) begin
                mcheck(a_addr == exp_a(bidx), "R9", a_addr, exp_a(bidx));
                mcheck(a_wdata == (exp_b(bidx)[7:0] ^ 8'hC3), "R4", a_wdata, exp_b(bidx)[7:0] ^ 8'hC3);
                nwr++; bidx++; last_wr = cyc;
            end
            if (done) begin dcnt++; done_cyc = cyc; end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_go(input logic [15:0] b);
        @(negedge clk);
        go = 1'b1; budget = b;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic prog(input logic [7:0] c, input logic [7:0] p, input logic [15:0] pg,
                        input logic [7:0] bk, input logic [15:0] n, input logic [15:0] offs);
        e_ctrl = c; e_port = p; e_page = pg; e_bank = bk; e_offs = offs;
        xfer_id++;
        wr_reg(3'd0, c);  wr_reg(3'd1, p);
        wr_reg(3'd2, pg[7:0]); wr_reg(3'd3, pg[15:8]); wr_reg(3'd4, bk);
        wr_reg(3'd5, n[7:0]);  wr_reg(3'd6, n[15:8]);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic end_checks(input int n, input logic [15:0] endp);
        logic [7:0] lo, hi, bk;
        check(nwr == n, "R10 byte count", nwr, n);
        check(dcnt == 1, "R11 done once", dcnt, 1);
        check(done_cyc == last_wr + 1, "R11 done timing", done_cyc, last_wr + 1);
        check(last_wr - first_rd == 2 * n - 1, "R3 span", last_wr - first_rd, 2 * n - 1);
        check(!busy, "R11 busy low", busy, 0);
        rd_reg(3'd2, lo); rd_reg(3'd3, hi);
        check({hi, lo} == endp, "R8 end address", {hi, lo}, endp);
        rd_reg(3'd4, bk);
        check(bk == e_bank, "R9 bank", bk, e_bank);
        rd_reg(3'd5, lo); rd_reg(3'd6, hi);
        check({hi, lo} == 16'h0, "R10 count zero", {hi, lo}, 0);
    endtask

    task automatic reset_checks();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), d);
            check(d == 8'h00, "R1 reg reset", d, 0);
        end
        check(!busy && !done && !a_rd && !a_wr && !b_rd && !b_wr, "R1 idle outputs",
              {busy, done, a_rd, a_wr, b_rd, b_wr}, 0);
    endtask

    initial begin
        logic [7:0] d, lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();
        mon_on = 1'b1;

        // R2 register map
        for (int a = 0; a < 7; a++) wr_reg(3'(a), 8'h31 + 8'(a * 17));
        for (int a = 0; a < 7; a++) begin
            rd_reg(3'(a), d);
            check(d == 8'h31 + 8'(a * 17), "R2 readback", d, 8'h31 + 8'(a * 17));
        end
        rd_reg(3'd7, d);
        check(d == 8'h00, "R2 offset 7", d, 0);

        // table: R4 R5 R6 R7 R8 R10 R11
        for (int v = 0; v < NV; v++) begin
            prog(VECS[v].ctrl, 8'h18, 16'h1000, 8'h7E, {8'h00, VECS[v].cnt}, VECS[v].offs);
            pulse_go(16'hFFFF);
            wait_idle();
            end_checks(int'(VECS[v].cnt), VECS[v].endp);
        end

        // R5 port wrap, R9 page wrap upward without bank carry
        prog(8'h04, 8'hFE, 16'hFFFF, 8'h7E, 16'd4, 16'hE4E4);
        pulse_go(16'hFFFF);
        wait_idle();
        end_checks(4, 16'h0003);

        // R9 page wrap downward without bank borrow
        prog(8'h90, 8'h40, 16'h0001, 8'h12, 16'd3, 16'h0000);
        pulse_go(16'hFFFF);
        wait_idle();
        end_checks(3, 16'hFFFE);

        // R12 writes while busy are dropped
        prog(8'h00, 8'h18, 16'h2000, 8'h7E, 16'd8, 16'h0000);
        pulse_go(16'hFFFF);
        wr_reg(3'd1, 8'h55);
        wr_reg(3'd0, 8'h80);
        wr_reg(3'd4, 8'h01);
        wait_idle();
        end_checks(8, 16'h2008);
        rd_reg(3'd1, d);
        check(d == 8'h18, "R12 port kept", d, 8'h18);
        rd_reg(3'd0, d);
        check(d == 8'h00, "R12 ctrl kept", d, 8'h00);

        // R13 budget pause / resume, R10 count 0 = 65536
        prog(8'h04, 8'h18, 16'h1000, 8'h7E, 16'd0, 16'hE4E4);
        pulse_go(16'd6);
        repeat (10) @(negedge clk);
        check(busy, "R13 paused busy", busy, 1);
        check(nwr == 3, "R13 bytes in budget", nwr, 3);
        check(dcnt == 0, "R13 no done", dcnt, 0);
        rd_reg(3'd5, lo); rd_reg(3'd6, hi);
        check({hi, lo} == 16'hFFFD, "R10 count from zero", {hi, lo}, 16'hFFFD);
        pulse_go(16'd1);
        repeat (6) @(negedge clk);
        check(nwr == 3, "R13 small budget no byte", nwr, 3);
        check(busy, "R13 still armed", busy, 1);
        pulse_go(16'd4);
        repeat (8) @(negedge clk);
        check(nwr == 5, "R13 resumed bytes", nwr, 5);
        rd_reg(3'd5, lo); rd_reg(3'd6, hi);
        check({hi, lo} == 16'hFFFB, "R13 count continues", {hi, lo}, 16'hFFFB);
        rd_reg(3'd2, lo); rd_reg(3'd3, hi);
        check({hi, lo} == 16'h1005, "R13 address continues", {hi, lo}, 16'h1005);

        // R1 reset while paused
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        $display("  [TB] %0d tests run, %0d failed", n_tests + m_tests, n_fail + m_fail);
        $finish;
    end

endmodule